// File: doc/BRIEF.md
# HDLC Receive Frame Check Sequence Checker

This block checks the frame check sequence on the receive side of an HDLC link. Destuffed serial bits reach it one per enabled clock, least significant bit first. A start-of-frame pulse presets a 16-bit CRC register. Each enabled bit then advances the register. An end-of-frame strobe compares the register against the fixed good-frame residue 0xF0B8 and sets a registered good/bad output. Flag hunting and zero-bit removal are done upstream.

A test mode gives direct serial access to the comparison register. On entry to test mode the register and a bit counter are cleared. Exactly sixteen enabled bits are then shifted straight into the register. After that the register is frozen, a done flag is raised, and the compare is repeated every cycle. A 16-bit corrupt mask is XORed into the compared value in both modes, so that any chosen bit can be forced wrong on purpose.

Top module: `fcs_check_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `fcs_ok` and `chk_done` are 0.
- R2: In normal mode (`test_en` low), `sof` presets the register to 0xFFFF. Each cycle with `bit_en` high advances it by one step of the CRC with polynomial x^16+x^12+x^5+1, taken LSB first: the feedback is register bit 0 XOR `bit_in`, the register shifts right, and when the feedback is 1 it is XORed with 0x8408.
- R3: In normal mode, an `eof` cycle without `sof` sets `fcs_ok` on the next edge to ((register XOR `corrupt_mask`) == 0xF0B8), using the register value before any bit taken in that same cycle. `fcs_ok` then holds until the next `eof` or `sof`.
- R4: In normal mode, `sof` clears `fcs_ok` on the next edge and takes priority over `eof`. A `bit_en` in the same cycle as `sof` is ignored.
- R5: A cycle with `bit_en` low leaves the register unchanged, whatever the value of `bit_in`.
- R6: In the first cycle that `test_en` is seen high, the register is cleared to 0 and the bit count restarts. A `bit_en` in that cycle is ignored.
- R7: In later test-mode cycles, each `bit_en` shifts the register right with `bit_in` entering bit 15. After sixteen bits, the first bit sent sits in bit 0.
- R8: `chk_done` rises on the edge that takes the sixteenth test bit and stays high while `test_en` stays high. Further `bit_en` cycles leave the register frozen.
- R9: While `chk_done` is high, `fcs_ok` is refreshed every cycle, one edge later, to ((register XOR `corrupt_mask`) == 0xF0B8). In test mode, `sof` and `eof` have no effect.
- R10: Dropping `test_en` clears `chk_done` on the next edge. The register keeps its test value until a `sof` or a bit changes it.
- R11: Setting any bit of `corrupt_mask` makes an otherwise matching compare report 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_in | input | 1 | Serial receive data bit |
| bit_en | input | 1 | Clock enable: bit_in is valid in this cycle |
| sof | input | 1 | Start-of-frame pulse, presets the CRC |
| eof | input | 1 | End-of-frame strobe, triggers the compare |
| test_en | input | 1 | Selects serial test access to the comparison register |
| corrupt_mask | input | 16 | Bits XORed into the compared value |
| fcs_ok | output | 1 | Compare result: 1 = residue matched |
| chk_done | output | 1 | Test load of sixteen bits complete |

## Verification
Normal mode is exercised with random frames that carry a correct trailing FCS, which must match, and with frames that have one flipped bit, which must fail. Frames with idle gaps and random data during the gaps show that disabled cycles do not advance the CRC. A `sof` that coincides with a bit shows the priority rule. In test mode, loading 0xF0B8 and then 0x1234 (the latter repaired by a matching mask) shows the shift order. A bit driven during the entry cycle, fifteen versus sixteen bits, and extra bits after done separate the clear, count and freeze behaviour. Leaving test mode and strobing `eof` shows that the loaded value is kept.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  parameter int unsigned FCS_W       = 16;
  parameter logic [15:0] FCS_POLY    = 16'h8408;
  parameter logic [15:0] FCS_PRESET  = 16'hFFFF;
  parameter logic [15:0] FCS_RESIDUE = 16'hF0B8;

  typedef enum logic [2:0] {
    RG_HOLD   = 3'd0,
    RG_PRESET = 3'd1,
    RG_CLEAR  = 3'd2,
    RG_CRC    = 3'd3,
    RG_SHIFT  = 3'd4
  } rg_op_e;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   test_en,
  input  logic   bit_en,
  input  logic   sof,
  input  logic   eof,
  output rg_op_e op,
  output logic   cmp_now,
  output logic   cmp_clr,
  output logic   done
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  logic             test_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             entering, active, room;

  always_comb begin
    entering = test_en & ~test_q;
    active   = test_en & test_q;
    room     = (cnt_q < CNT_FULL);

    if (entering)                    op = RG_CLEAR;
    else if (active)                 op = (bit_en && room) ? RG_SHIFT : RG_HOLD;
    else if (sof)                    op = RG_PRESET;
    else if (bit_en)                 op = RG_CRC;
    else                             op = RG_HOLD;

    cmp_now = active ? done_q : (!test_en && !sof && eof);
    cmp_clr = !test_en && sof;

    cnt_d  = cnt_q;
    done_d = done_q;
    if (!test_en || entering) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (op == RG_SHIFT) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      test_q <= test_en;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  AST_DONE_DROP:   assert property (@(posedge clk) disable iff (!rst_n) !test_en |=> !done); // R10
  AST_DONE_STAYS:  assert property (@(posedge clk) disable iff (!rst_n) (done && test_en) |=> done); // R8
  AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_FULL); // R8
  AST_NO_SHIFT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (op != RG_SHIFT)); // R8
endmodule

// File: rtl/fcs_shreg.sv
module fcs_shreg
  import fcs_pkg::*;
#(
  parameter int unsigned  W      = 16,
  parameter logic [W-1:0] POLY   = 16'h8408,
  parameter logic [W-1:0] PRESET = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rg_op_e       op,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d, crc_nx, shf_nx;
  logic         fb;

  assign fb = q_r[0] ^ bit_in;

  for (genvar i = 0; i < W; i++) begin : g_step
    if (i == W - 1) begin : g_top
      assign crc_nx[i] = fb & POLY[i];
      assign shf_nx[i] = bit_in;
    end else begin : g_mid
      assign crc_nx[i] = q_r[i+1] ^ (fb & POLY[i]);
      assign shf_nx[i] = q_r[i+1];
    end
  end

  always_comb begin
    unique case (op)
      RG_PRESET: q_d = PRESET;
      RG_CLEAR:  q_d = '0;
      RG_CRC:    q_d = crc_nx;
      RG_SHIFT:  q_d = shf_nx;
      default:   q_d = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= PRESET;
    else        q_r <= q_d;
  end

  assign q = q_r;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (op == RG_HOLD) |=> $stable(q_r)); // R5
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (op == RG_SHIFT) |=> (q_r[W-1] == $past(bit_in))); // R7
endmodule

// File: rtl/fcs_cmp.sv
module fcs_cmp #(
  parameter int unsigned  W       = 16,
  parameter logic [W-1:0] RESIDUE = 16'hF0B8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_now,
  input  logic         cmp_clr,
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  output logic         good
);
  logic good_q, good_d, match;

  always_comb begin
    match  = ((value ^ mask) == RESIDUE);
    good_d = good_q;
    if (cmp_clr)      good_d = 1'b0;
    else if (cmp_now) good_d = match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= good_d;
  end

  assign good = good_q;

  AST_GOOD_CLR:  assert property (@(posedge clk) disable iff (!rst_n) cmp_clr |=> !good); // R4
  AST_GOOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cmp_now && !cmp_clr) |=> $stable(good)); // R3
endmodule

// File: rtl/fcs_check_rx.sv
module fcs_check_rx
  import fcs_pkg::*;
#(
  parameter int unsigned       W       = FCS_W,
  parameter logic [W-1:0]      POLY    = FCS_POLY,
  parameter logic [W-1:0]      PRESET  = FCS_PRESET,
  parameter logic [W-1:0]      RESIDUE = FCS_RESIDUE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         bit_en,
  input  logic         sof,
  input  logic         eof,
  input  logic         test_en,
  input  logic [W-1:0] corrupt_mask,
  output logic         fcs_ok,
  output logic         chk_done
);
  logic [1:0]   rst_sync;
  logic         rst_i_n;
  rg_op_e       op;
  logic         cmp_now, cmp_clr;
  logic [W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  fcs_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .test_en (test_en),
    .bit_en  (bit_en),
    .sof     (sof),
    .eof     (eof),
    .op      (op),
    .cmp_now (cmp_now),
    .cmp_clr (cmp_clr),
    .done    (chk_done)
  );

  fcs_shreg #(.W(W), .POLY(POLY), .PRESET(PRESET)) u_reg (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .op     (op),
    .bit_in (bit_in),
    .q      (crc_q)
  );

  fcs_cmp #(.W(W), .RESIDUE(RESIDUE)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cmp_now (cmp_now),
    .cmp_clr (cmp_clr),
    .value   (crc_q),
    .mask    (corrupt_mask),
    .good    (fcs_ok)
  );

  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_i_n) (chk_done && test_en) |=> $stable(crc_q)); // R8
  AST_SOF_NO_GOOD:       assert property (@(posedge clk) disable iff (!rst_i_n) (sof && !test_en) |=> !fcs_ok); // R4
  AST_RESET_QUIET:       assert property (@(posedge clk) !rst_i_n |-> (!fcs_ok && !chk_done)); // R1
endmodule

// File: tb/sim_fcs_check_rx.sv
module sim_fcs_check_rx;
  logic        clk = 1'b0;
  logic        rst_n, bit_in, bit_en, sof, eof, test_en;
  logic [15:0] corrupt_mask;
  logic        fcs_ok, chk_done;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  logic  model_on = 1'b0;
  logic  fq[$];

  logic [15:0] m_reg;
  logic        m_good, m_done, m_tq;
  int          m_cnt;

  always #10 clk = ~clk;

  fcs_check_rx u0 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en), .sof(sof),
    .eof(eof), .test_en(test_en), .corrupt_mask(corrupt_mask),
    .fcs_ok(fcs_ok), .chk_done(chk_done)
  );

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fbk;
    fbk = c[0] ^ b;
    c = c >> 1;
    if (fbk) c = c ^ 16'h8408;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 16'hFFFF; m_good = 0; m_done = 0; m_tq = 0; m_cnt = 0;
    end else begin
      if (test_en) begin
        if (!m_tq) begin
          m_reg = 16'h0000; m_cnt = 0; m_done = 0;
        end else begin
          if (m_done) m_good = ((m_reg ^ corrupt_mask) == 16'hF0B8);
          if (bit_en && m_cnt < 16) begin
            m_reg = {bit_in, m_reg[15:1]};
            m_cnt++;
            if (m_cnt == 16) m_done = 1;
          end
        end
      end else begin
        m_done = 0; m_cnt = 0;
        if (sof) begin
          m_reg = 16'hFFFF; m_good = 0;
        end else begin
          if (eof) m_good = ((m_reg ^ corrupt_mask) == 16'hF0B8);
          if (bit_en) m_reg = crc_step(m_reg, bit_in);
        end
      end
      m_tq = test_en;
    end
  end

  task automatic cmp_model();
    if (model_on) begin
      checks++;
      if (fcs_ok !== m_good || chk_done !== m_done) begin
        errors++;
        $display("FAIL %s model: fcs_ok=%b chk_done=%b expected fcs_ok=%b chk_done=%b",
                 cur_req, fcs_ok, chk_done, m_good, m_done);
      end
    end
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cyc(input logic be, input logic b, input logic s, input logic e);
    @(negedge clk);
    cmp_model();
    bit_en = be; bit_in = b; sof = s; eof = e;
  endtask

  task automatic idle_peek();
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic set_test(input logic v, input logic be, input logic b);
    @(negedge clk);
    cmp_model();
    test_en = v; bit_en = be; bit_in = b; sof = 0; eof = 0;
  endtask

  task automatic build_frame(input int nbytes, input bit corrupt);
    logic [15:0] c;
    logic [7:0]  v;
    int          idx;
    c = 16'hFFFF;
    fq.delete();
    for (int k = 0; k < nbytes; k++) begin
      v = 8'($urandom_range(0, 255));
      for (int i = 0; i < 8; i++) begin
        fq.push_back(v[i]);
        c = crc_step(c, v[i]);
      end
    end
    c = ~c;
    for (int i = 0; i < 16; i++) fq.push_back(c[i]);
    if (corrupt) begin
      idx = $urandom_range(0, fq.size() - 1);
      fq[idx] = ~fq[idx];
    end
  endtask

  task automatic play_frame(input bit gaps);
    foreach (fq[i]) begin
      if (gaps && ($urandom_range(0, 2) == 0))
        cyc(1'b0, 1'($urandom_range(0, 1)), 1'b0, 1'b0);
      cyc(1'b1, fq[i], 1'b0, 1'b0);
    end
  endtask

  task automatic run_frame(input int nbytes, input bit corrupt, input bit gaps,
                           input bit sof_bit, input string req, input logic exp);
    cur_req = req;
    build_frame(nbytes, corrupt);
    cyc(sof_bit, 1'b1, 1'b1, 1'b0);
    play_frame(gaps);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    idle_peek();
    chk(req, fcs_ok, exp);
  endtask

  task automatic load_word(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, w[i], 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; bit_in = 0; bit_en = 0; sof = 0; eof = 0; test_en = 0; corrupt_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset good", fcs_ok, 1'b0);
    chk("R1 reset done", chk_done, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", fcs_ok | chk_done, 1'b0);
    model_on = 1;

    // R2 / R3 good and corrupted frames
    for (int n = 0; n < 6; n++) run_frame(2 + n, 1'b0, 1'b0, 1'b0, "R3", 1'b1);
    for (int n = 0; n < 6; n++) run_frame(3 + n, 1'b1, 1'b0, 1'b0, "R2", 1'b0);
    // R5 gaps with random data on disabled cycles
    for (int n = 0; n < 4; n++) run_frame(4, 1'b0, 1'b1, 1'b0, "R5", 1'b1);
    // R4 sof with a coincident bit
    run_frame(3, 1'b0, 1'b0, 1'b1, "R4", 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    idle_peek();
    chk("R4 sof beats eof", fcs_ok, 1'b0);
    // R11 mask in normal mode
    corrupt_mask = 16'h0020;
    run_frame(3, 1'b0, 1'b0, 1'b0, "R11", 1'b0);
    corrupt_mask = 16'h0000;

    // R6 entry with a bit, then R7/R8 load of the residue
    cur_req = "R6";
    set_test(1'b1, 1'b1, 1'b1);
    load_word(16'hF0B8, 15);
    idle_peek();
    chk("R8 fifteen bits", chk_done, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    idle_peek();
    chk("R8 done after sixteen", chk_done, 1'b1);
    idle_peek();
    chk("R6 residue loaded", fcs_ok, 1'b1);
    cur_req = "R8";
    load_word(16'h0F47, 16);
    idle_peek(); idle_peek();
    chk("R8 frozen", fcs_ok, 1'b1);
    cur_req = "R9";
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    idle_peek();
    chk("R9 sof ignored in test", fcs_ok, 1'b1);
    corrupt_mask = 16'h0080;
    idle_peek(); idle_peek();
    chk("R11 test corrupt", fcs_ok, 1'b0);
    corrupt_mask = 16'h0001;
    cur_req = "R10";
    set_test(1'b0, 1'b0, 1'b0);
    idle_peek();
    chk("R10 done drops", chk_done, 1'b0);
    corrupt_mask = 16'h0000;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    idle_peek();
    chk("R10 value kept", fcs_ok, 1'b1);

    // R7 bit order with another word, repaired by mask
    cur_req = "R7";
    set_test(1'b1, 1'b0, 1'b0);
    load_word(16'h1234, 16);
    idle_peek(); idle_peek();
    chk("R7 other word fails", fcs_ok, 1'b0);
    corrupt_mask = 16'hE28C;
    idle_peek(); idle_peek();
    chk("R7 mask repairs", fcs_ok, 1'b1);
    corrupt_mask = 16'h0000;
    set_test(1'b0, 1'b0, 1'b0);
    idle_peek();

    // R2 normal mode again after test
    run_frame(5, 1'b0, 1'b1, 1'b0, "R2", 1'b1);
    repeat (3) idle_peek();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule